// File: doc/BRIEF.md
# SDRAM Init and Refresh Controller

This block sits on the host side of a two-bank single-data-rate SDRAM that has a 10-bit row address and an 8-bit column address. After reset it holds the memory in a safe state for a programmable settling time. It then runs the start-up sequence: close every bank, run a burst of refresh cycles, and load the mode register. Once the start-up sequence is complete, it opens the user port.

The user port is a simple valid/ready interface that carries one 32-bit word per request. Each accepted request becomes a closed-page access: open the row, issue one column read or write, then close the bank. Refresh is timed by an internal interval counter. A pending refresh always wins over a new request.

Every minimum command spacing is a parameter counted in clock cycles. All pins are driven from registers. Read data is captured a fixed number of cycles after the read command, set by the programmed CAS latency.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: From reset until the mode-register load, `sd_cke` is 1 and `sd_dqm` is 4'hF. For at least `INIT_CYC` cycles after reset, the only command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111).
- R2: Start-up order is fixed: one precharge with A9=1 (both banks), then exactly `INIT_REFS` auto-refresh commands, then one mode-register load. `init_done` is 1 from the cycle the mode-register load appears on the pins. Until then `req_ready` is 0 and no ACT is issued.
- R3: The mode-register load drives BA=0 and the following address fields: A2..A0=000 (burst of one), A3=0 (sequential), A6..A4=`CAS_LAT`, A8..A7=00, A9=1 (single-word writes).
- R4: Spacing limits: after a precharge, the next command waits at least `T_RP` cycles. After a refresh, it waits at least `T_RC` cycles. After a mode-register load, it waits at least `T_RSC` cycles.
- R5: Inside an access, spacing limits are: ACT to READ/WRITE ≥ `T_RCD`; ACT to PRE ≥ `T_RAS`; WRITE to PRE ≥ `T_DPL`.
- R6: Commands on {cs_n,ras_n,cas_n,we_n} use these encodings: MRS 0000, REF 0001, PRE 0010, ACT 0011, WRITE 0100, READ 0101, NOP 0111. Each access is ACT, then one READ or WRITE with A9=0 to the same bank, then PRE with A9=0 to that bank. REF and MRS are issued only while both banks are closed.
- R7: The request address maps as follows: bit 18 is the bank, bits 17..8 are the row (driven on A9..A0 with ACT), and bits 7..0 are the column (driven on A7..A0 with READ/WRITE).
- R8: After start-up, refresh requests arise every `REF_INT` cycles. A pending refresh is issued before any new request. The gap between refreshes never exceeds `REF_INT` plus the length of one access.
- R9: `req_ready` is 1 only when the controller is idle, started up and has no refresh pending. A request is taken on the edge where `req_valid` and `req_ready` are both 1, and each taken request produces exactly one access.
- R10: `sd_dq_oe` is 1 only in WRITE cycles. In those cycles `sd_dq_out` carries the request's write data and `sd_dqm` is 0.
- R11: A read raises `rd_valid` for one cycle, `CAS_LAT`+1 cycles after READ appears on the pins. `rd_data` is the value on `sd_dq_in` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this edge when valid |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Captured read word |
| init_done | output | 1 | Start-up sequence complete |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_a | output | 10 | Multiplexed address; A9 selects all-bank precharge |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_out | output | 32 | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Read data from memory |

## Verification
A corrupt wait count would show on the command pins as two commands placed too close together, because every command is checked against the last precharge, refresh, activate and write to its bank. A state machine stuck in a stray state would show within one refresh interval as a missing refresh or an out-of-order command. A mis-latched request or a wrong read-pipeline depth would show at the next ACT as a wrong bank or row, or `CAS_LAT`+1 cycles after the read as a missing, extra or wrong `rd_valid` word. Start-up faults show before the first user request: too few NOPs, a wrong refresh count or a wrong mode word.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

    localparam int BA_W   = 1;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 8;
    localparam int DQ_W   = 32;
    localparam int DQM_W  = DQ_W / 8;
    localparam int ADDR_W = BA_W + ROW_W + COL_W;
    localparam int AP_BIT = 9;   // address bit selecting all-bank precharge

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_POWER,
        ST_INIT_REF,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_ACCESS,
        ST_CLOSE
    } ctl_state_e;

    typedef struct packed {
        sdr_cmd_e          cmd;
        logic [BA_W-1:0]   ba;
        logic [ROW_W-1:0]  a;
    } sdr_bus_t;

    typedef struct packed {
        logic              wr;
        logic [BA_W-1:0]   ba;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DQ_W-1:0]   data;
    } acc_t;

    function automatic int imax(int x, int y);
        return (x > y) ? x : y;
    endfunction

    // burst of one, sequential, latency in A6..A4, single-word writes
    function automatic logic [ROW_W-1:0] mode_word(int cl);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[6:4] = cl[2:0];
        m[9]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
    parameter int W        = 8,
    parameter int INIT_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= W'(INIT_VAL);
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // spacing windows shrink by exactly one per cycle
    assert_gap_countdown_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 2083
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt;
    logic         expire;

    assign expire = en && (cnt == W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || !en)   cnt <= '0;
        else if (expire)  cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          pend <= 1'b0;
        else if (expire)  pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end

    assert_ack_only_pending_R8: assert property (@(posedge clk) disable iff (rst)
        ack |-> pend);

    assert_pend_from_interval_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(expire));

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe #(
    parameter int CL = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    // stage k is set k edges after the edge that put READ on the pins
    logic [CL:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            stage    <= {stage[CL-1:0], launch};
            rd_valid <= stage[CL];
            if (stage[CL]) rd_data <= dq_in;
        end
    end

    assert_single_read_inflight_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage));

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdr_ctrl_pkg::*;
#(
    parameter int INIT_CYC  = 26667,
    parameter int INIT_REFS = 8,
    parameter int REF_INT   = 2083,
    parameter int T_RC      = 9,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RSC     = 2,
    parameter int T_DPL     = 1,
    parameter int CAS_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              init_done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    localparam int RD2PRE  = imax(T_RAS - T_RCD, 1);
    localparam int WR2PRE  = imax(imax(T_RAS - T_RCD, T_DPL), 1);
    localparam int GAP_MAX = imax(INIT_CYC, imax(T_RC, imax(T_RP, imax(T_RCD,
                             imax(RD2PRE, imax(WR2PRE, T_RSC))))));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int REFS_W  = $clog2(INIT_REFS + 1);

    function automatic logic [GAP_W-1:0] gapv(int t);
        return GAP_W'(t - 1);
    endfunction

    ctl_state_e         st, st_n;
    acc_t               acc, acc_n;
    sdr_bus_t           bus_n, bus_q;
    logic [REFS_W-1:0]  refs_left, refs_left_n;
    logic               done_q, done_n;
    logic               gap_load, gap_zero;
    logic [GAP_W-1:0]   gap_val;
    logic               ref_pend, ref_ack;
    logic               launch, wr_n, oe_q;
    logic [DQ_W-1:0]    dq_q;
    logic [DQM_W-1:0]   dqm_q;

    sdr_gap_timer #(.W(GAP_W), .INIT_VAL(INIT_CYC)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .val(gap_val), .zero(gap_zero));

    sdr_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
        .clk(clk), .rst(rst), .en(done_q), .ack(ref_ack), .pend(ref_pend));

    sdr_read_pipe #(.CL(CAS_LAT), .DW(DQ_W)) u_rd (
        .clk(clk), .rst(rst), .launch(launch), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data));

    always_comb begin
        st_n        = st;
        acc_n       = acc;
        refs_left_n = refs_left;
        done_n      = done_q;
        bus_n       = '{cmd: CMD_NOP, ba: '0, a: '0};
        gap_load    = 1'b0;
        gap_val     = '0;
        ref_ack     = 1'b0;
        launch      = 1'b0;
        wr_n        = 1'b0;
        req_ready   = (st == ST_IDLE) && gap_zero && !ref_pend;
        if (gap_zero) begin
            case (st)
                ST_POWER: begin
                    bus_n.cmd       = CMD_PRE;
                    bus_n.a[AP_BIT] = 1'b1;
                    gap_load        = 1'b1;
                    gap_val         = gapv(T_RP);
                    st_n            = ST_INIT_REF;
                end
                ST_INIT_REF: begin
                    bus_n.cmd   = CMD_REF;
                    gap_load    = 1'b1;
                    gap_val     = gapv(T_RC);
                    refs_left_n = refs_left - 1'b1;
                    if (refs_left == REFS_W'(1)) st_n = ST_LOAD_MODE;
                end
                ST_LOAD_MODE: begin
                    bus_n.cmd = CMD_MRS;
                    bus_n.a   = mode_word(CAS_LAT);
                    gap_load  = 1'b1;
                    gap_val   = gapv(T_RSC);
                    done_n    = 1'b1;
                    st_n      = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        bus_n.cmd = CMD_REF;
                        gap_load  = 1'b1;
                        gap_val   = gapv(T_RC);
                        ref_ack   = 1'b1;
                    end else if (req_valid) begin
                        acc_n = '{wr:   req_write,
                                  ba:   req_addr[ADDR_W-1 -: BA_W],
                                  row:  req_addr[COL_W +: ROW_W],
                                  col:  req_addr[COL_W-1:0],
                                  data: req_wdata};
                        bus_n.cmd = CMD_ACT;
                        bus_n.ba  = acc_n.ba;
                        bus_n.a   = acc_n.row;
                        gap_load  = 1'b1;
                        gap_val   = gapv(T_RCD);
                        st_n      = ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    bus_n.cmd = acc.wr ? CMD_WR : CMD_RD;
                    bus_n.ba  = acc.ba;
                    bus_n.a   = ROW_W'(acc.col);
                    gap_load  = 1'b1;
                    gap_val   = acc.wr ? gapv(WR2PRE) : gapv(RD2PRE);
                    wr_n      = acc.wr;
                    launch    = !acc.wr;
                    st_n      = ST_CLOSE;
                end
                ST_CLOSE: begin
                    bus_n.cmd = CMD_PRE;
                    bus_n.ba  = acc.ba;
                    gap_load  = 1'b1;
                    gap_val   = gapv(T_RP);
                    st_n      = ST_IDLE;
                end
                default: st_n = ST_POWER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_POWER;
            acc       <= '0;
            refs_left <= REFS_W'(INIT_REFS);
            done_q    <= 1'b0;
            bus_q     <= '{cmd: CMD_NOP, ba: '0, a: '0};
            oe_q      <= 1'b0;
            dq_q      <= '0;
            dqm_q     <= '1;
        end else begin
            st        <= st_n;
            acc       <= acc_n;
            refs_left <= refs_left_n;
            done_q    <= done_n;
            bus_q     <= bus_n;
            oe_q      <= wr_n;
            dq_q      <= wr_n ? acc.data : '0;
            dqm_q     <= done_n ? '0 : '1;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_q.cmd;
    assign sd_ba     = bus_q.ba;
    assign sd_a      = bus_q.a;
    assign sd_cke    = 1'b1;
    assign sd_dqm    = dqm_q;
    assign sd_dq_out = dq_q;
    assign sd_dq_oe  = oe_q;
    assign init_done = done_q;

    assert_ready_after_init_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> done_q);

    assert_refresh_beats_request_R8: assert property (@(posedge clk) disable iff (rst)
        (ref_pend && st == ST_IDLE) |-> !req_ready);

    assert_dqm_high_in_init_R1: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> (sd_dqm == '1));

    assert_rw_no_autoprecharge_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_q.cmd == CMD_RD || bus_q.cmd == CMD_WR) |-> !bus_q.a[AP_BIT]);

    assert_drive_only_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (bus_q.cmd == CMD_WR && sd_dqm == '0));

endmodule

// File: tb/tb_sdram_seq_ctrl.sv
module tb_sdram_seq_ctrl;
    import sdr_ctrl_pkg::*;

    localparam int INIT_CYC = 50, REFS = 8, REF_INT = 150, CL = 3;
    localparam int T_RC = 9, T_RP = 3, T_RCD = 3, T_RAS = 6, T_RSC = 2, T_DPL = 1;
    localparam int SLACK = T_RCD + imax(T_RAS - T_RCD, T_DPL) + T_RP + 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_ready;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0, rd_data, sd_dq_out, sd_dq_in = '0;
    logic rd_valid, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [0:0] sd_ba;
    logic [9:0] sd_a;
    logic [3:0] sd_dqm;

    sdram_seq_ctrl #(.INIT_CYC(INIT_CYC), .INIT_REFS(REFS), .REF_INT(REF_INT),
        .T_RC(T_RC), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RSC(T_RSC),
        .T_DPL(T_DPL), .CAS_LAT(CL)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    int nchk = 0, nbad = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    endtask

    typedef struct { bit wr; logic [18:0] addr; logic [31:0] d; } req_t;
    req_t pq[$];
    req_t cur;
    logic [31:0] mem [int];
    int drv_cyc[$], exp_cyc[$];
    logic [31:0] drv_dat[$], exp_dat[$];

    int phase = 0, init_refs = 0, mrs_cyc = -1000;
    int last_pre = -1000, last_ref = -1000;
    int last_act [2] = '{-1000, -1000};
    int last_wr  [2] = '{-1000, -1000};
    bit open_b   [2] = '{0, 0};

    function automatic logic [31:0] memval(logic [18:0] ad);
        if (mem.exists(int'(ad))) return mem[int'(ad)];
        return {13'h1A5, ad};
    endfunction

    // cycle-by-cycle reference model of memory, command timing and read return
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [3:0] c;
            int b;
            bit rexp;
            cyc++;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            b = int'(sd_ba);
            if (drv_cyc.size() > 0 && drv_cyc[0] == cyc) begin
                sd_dq_in = drv_dat.pop_front();
                void'(drv_cyc.pop_front());
            end else sd_dq_in = 32'h5A5A0000 | 32'(cyc[15:0]);
            rexp = (exp_cyc.size() > 0 && exp_cyc[0] == cyc);
            chk(rd_valid == rexp, "R11", "rd_valid", rd_valid, rexp);
            if (rexp) begin
                chk(rd_data == exp_dat[0], "R11", "rd_data", rd_data, exp_dat[0]);
                void'(exp_cyc.pop_front()); void'(exp_dat.pop_front());
            end
            chk(sd_dq_oe == (c == 4'b0100), "R10", "oe vs write", sd_dq_oe, c == 4'b0100);
            if (phase < 2 && c != 4'b0000) begin
                chk(sd_cke && sd_dqm == 4'hF, "R1", "cke/dqm during init", {sd_cke, sd_dqm}, 5'h1F);
                chk(!req_ready, "R9", "ready before init", req_ready, 0);
            end
            case (c)
                4'b0111: ;
                4'b0010: begin
                    chk(cyc - last_ref >= T_RC, "R4", "REF->PRE", cyc - last_ref, T_RC);
                    chk(cyc - mrs_cyc >= T_RSC, "R4", "MRS->PRE", cyc - mrs_cyc, T_RSC);
                    if (phase == 0) begin
                        chk(cyc - 1 >= INIT_CYC, "R1", "nop cycles", cyc - 1, INIT_CYC);
                        chk(sd_a[9] == 1'b1, "R2", "first PRE all-bank", sd_a[9], 1);
                        phase = 1;
                    end else begin
                        chk(sd_a[9] == 1'b0 && open_b[b], "R6", "PRE of open bank", {sd_a[9], open_b[b]}, 1);
                        chk(cyc - last_act[b] >= T_RAS, "R5", "ACT->PRE", cyc - last_act[b], T_RAS);
                        chk(cyc - last_wr[b] >= T_DPL, "R5", "WR->PRE", cyc - last_wr[b], T_DPL);
                        open_b[b] = 0;
                    end
                    last_pre = cyc;
                end
                4'b0001: begin
                    chk(phase >= 1, "R2", "REF before PRE", phase, 1);
                    chk(!open_b[0] && !open_b[1], "R6", "REF with open bank", {open_b[0], open_b[1]}, 0);
                    chk(cyc - last_pre >= T_RP, "R4", "PRE->REF", cyc - last_pre, T_RP);
                    chk(cyc - last_ref >= T_RC, "R4", "REF->REF", cyc - last_ref, T_RC);
                    chk(cyc - mrs_cyc >= T_RSC, "R4", "MRS->REF", cyc - mrs_cyc, T_RSC);
                    if (phase == 1) init_refs++;
                    else chk(cyc - (last_ref > mrs_cyc ? last_ref : mrs_cyc) <= REF_INT + SLACK,
                             "R8", "refresh gap", cyc - last_ref, REF_INT + SLACK);
                    last_ref = cyc;
                end
                4'b0000: begin
                    chk(phase == 1, "R2", "MRS order", phase, 1);
                    chk(init_refs == REFS, "R2", "init refresh count", init_refs, REFS);
                    chk(sd_a == {1'b1, 2'b00, 3'(CL), 1'b0, 3'b000}, "R3", "mode word", sd_a,
                        {1'b1, 2'b00, 3'(CL), 1'b0, 3'b000});
                    chk(sd_ba == 1'b0, "R3", "mode bank", sd_ba, 0);
                    chk(cyc - last_ref >= T_RC, "R4", "REF->MRS", cyc - last_ref, T_RC);
                    phase = 2; mrs_cyc = cyc;
                end
                4'b0011: begin
                    chk(phase == 2, "R2", "ACT before init", phase, 2);
                    chk(cyc - last_pre >= T_RP, "R4", "PRE->ACT", cyc - last_pre, T_RP);
                    chk(cyc - last_ref >= T_RC, "R4", "REF->ACT", cyc - last_ref, T_RC);
                    chk(cyc - mrs_cyc >= T_RSC, "R4", "MRS->ACT", cyc - mrs_cyc, T_RSC);
                    chk(pq.size() > 0, "R9", "ACT without request", pq.size(), 1);
                    if (pq.size() > 0) cur = pq.pop_front();
                    chk({sd_ba, sd_a} == cur.addr[18:8], "R7", "bank/row", {sd_ba, sd_a}, cur.addr[18:8]);
                    open_b[b] = 1; last_act[b] = cyc;
                end
                4'b0100, 4'b0101: begin
                    chk(open_b[b], "R6", "RW to closed bank", open_b[b], 1);
                    chk({sd_ba, sd_a} == {cur.addr[18], 2'b00, cur.addr[7:0]}, "R7", "bank/col, A9=0",
                        {sd_ba, sd_a}, {cur.addr[18], 2'b00, cur.addr[7:0]});
                    chk((c == 4'b0100) == cur.wr, "R6", "direction", c, cur.wr);
                    chk(cyc - last_act[b] >= T_RCD, "R5", "ACT->RW", cyc - last_act[b], T_RCD);
                    if (c == 4'b0100) begin
                        chk(sd_dq_out == cur.d && sd_dqm == 4'h0, "R10", "write data", sd_dq_out, cur.d);
                        mem[int'(cur.addr)] = sd_dq_out;
                        last_wr[b] = cyc;
                    end else begin
                        drv_cyc.push_back(cyc + CL);     drv_dat.push_back(memval(cur.addr));
                        exp_cyc.push_back(cyc + CL + 1); exp_dat.push_back(memval(cur.addr));
                    end
                end
                default: chk(0, "R6", "unexpected command", c, 4'b0111);
            endcase
            chk(init_done == (phase == 2), "R2", "init_done", init_done, phase == 2);
        end
    end

    task automatic access(bit wr, logic [18:0] ad, logic [31:0] d);
        req_t r;
        r.wr = wr; r.addr = ad; r.d = d;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = ad; req_wdata = d;
        while (!req_ready) @(negedge clk);
        pq.push_back(r);
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    function automatic logic [18:0] mk(int ba, int row, int col);
        return {1'(ba), 10'(row), 8'(col)};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state (R1, R9, R11)
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset cmd", 0, 7);
        chk(sd_cke && sd_dqm == 4'hF, "R1", "reset cke/dqm", {sd_cke, sd_dqm}, 5'h1F);
        chk(!init_done && !req_ready, "R9", "reset ready", {init_done, req_ready}, 0);
        chk(!rd_valid && !sd_dq_oe, "R11", "reset rd_valid", {rd_valid, sd_dq_oe}, 0);
        @(posedge clk); #1 rst = 0;
        wait (init_done);
        access(1, mk(0, 0, 0), 32'h11111111);
        access(1, mk(1, 1023, 255), 32'hFFFF0001);
        access(1, mk(0, 5, 17), 32'hA0A0A0A0);
        access(1, mk(1, 5, 17), 32'h0B0B0B0B);
        access(0, mk(0, 0, 0), 0);
        access(0, mk(1, 1023, 255), 0);
        access(0, mk(0, 5, 17), 0);
        access(0, mk(1, 5, 17), 0);
        access(0, mk(1, 77, 3), 0);
        access(1, mk(0, 0, 0), 32'hCAFEF00D);
        access(0, mk(0, 0, 0), 0);
        repeat (4 * REF_INT) @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            access(1, mk(i & 1, (i * 37) % 1024, (i * 91) % 256), 32'h1000_0000 + i * 32'h0101_0101);
            access(0, mk(i & 1, (i * 37) % 1024, (i * 91) % 256), 0);
        end
        repeat (40) @(negedge clk);
        chk(exp_cyc.size() == 0 && pq.size() == 0, "R11", "reads outstanding", exp_cyc.size(), 0);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R9", "watchdog expired", cyc, 0);
        report();
    end

endmodule